// File: doc/BRIEF.md
# Byte-Fed Dual Converter Code Loader

This block is the digital front end of a two-channel 12-bit converter driven from an 8-bit processor bus. Each channel keeps a 12-bit staging word and a 12-bit output code. A bus write puts one byte into one of four staging parts. These parts are the low byte and the high nibble of channel A and of channel B, and the two-bit address picks which one. The high nibble is taken right-justified from the bus. The staging parts may be filled in any order. While the shared load strobe is high, filling them does not change either output code.

The shared active-low load strobe works independently of chip select and write. While it is low, both output codes follow their staging words. When it rises, both codes keep their last value, so the two channels always update together.

The bus strobes, address and data come from outside the clock domain. Each passes through a two-flop synchronizer, and the level-sensitive behaviour is then reproduced in the system clock. A change at the pins therefore reaches an output code three clock edges after the synchronizer has captured it.

Top module: `dual_dac_loader`

## Requirements
- R1: After a synchronous active-low reset, both output codes are zero and all four staging parts hold zero.
- R2: The address selects the staging part: 0 is channel A bits 7..0, 1 is channel A bits 11..8, 2 is channel B bits 7..0, and 3 is channel B bits 11..8. A write changes only the selected part.
- R3: A staging part is loaded only while chip select and write are both low. If either is high, nothing is loaded.
- R4: A high-nibble write takes bus bits 3..0. Bus bits 7..4 are ignored for these addresses.
- R5: While the load strobe is high, writes to the staging parts leave both output codes unchanged.
- R6: While the load strobe is low, each output code follows its channel's staging word. The output reflects a change within four clock cycles once the synchronized strobe is low.
- R7: After the load strobe rises, both output codes hold the value captured at that edge, whatever writes follow.
- R8: A load pulse transfers both words while chip select is high and no write is in progress.
- R9: If the load strobe is low during a write and stays low for at least 2 clock cycles after write or chip select rises, the codes end up holding the final written data.
- R10: While chip select and write stay low, the selected part follows the bus. The value kept is the one present when the write ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| ld_n | input | 1 | Active-low shared load strobe (asynchronous) |
| addr | input | 2 | Staging part select |
| data | input | 8 | Bus data byte |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The main sweep sends every byte value to every address. After each write it checks that the codes have not moved, then pulses the load strobe and compares both codes with a word assembled arithmetically in the bench. This catches a wrong address decode, a swapped nibble, and upper bus bits leaking into the high nibble. Separate patterns cover the remaining cases:
- Writes blocked by chip select or by write alone show whether either gate is missing.
- Writes made while the load strobe is low tell the transparent state apart from the held state.
- An overlapped write followed by a delayed strobe release checks that the final data is captured.
- Changing the data in the middle of a write shows that the part follows the bus level rather than capturing on the falling strobe edge.

// File: rtl/ddl_pkg.sv
// Shared widths and helpers for the dual converter code loader.
// Assumes two channels, each split into a low byte part and a high part.
package ddl_pkg;
    localparam int BUS_W      = 8;
    localparam int CODE_W     = 12;
    localparam int NUM_CH     = 2;
    localparam int PARTS_CH   = 2;
    localparam int NUM_PARTS  = NUM_CH * PARTS_CH;
    localparam int SEL_W      = $clog2(NUM_PARTS);

    // Index of a staging part: low part is even, high part is odd
    function automatic int part_idx(input int ch, input bit hi);
        return ch * PARTS_CH + (hi ? 1 : 0);
    endfunction
endpackage

// File: rtl/ddl_sync.sv
// Multi-stage synchronizer for a bus of asynchronous inputs.
// Assumes synchronous active-low reset; every bit resets to RST_VAL.
module ddl_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sample one stage further down the chain
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d_in;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/ddl_channel.sv
// One converter channel: split staging word plus output code register.
// Assumes enables come from the synchronized strobe domain; the output
// register follows the staging word whenever xfer_en is high.
module ddl_channel #(
    parameter int BUS_W  = 8,
    parameter int CODE_W = 12,
    localparam int HI_W  = CODE_W - BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic [BUS_W-1:0]  bus,
    input  logic              xfer_en,
    output logic [CODE_W-1:0] stage_word,
    output logic [CODE_W-1:0] code
);
    logic [BUS_W-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;

    // Low part follows the bus while its enable is held
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_en) lo_q <= bus;
    end

    // High part takes right-justified bits from the bus
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_en) hi_q <= bus[HI_W-1:0];
    end

    assign stage_word = {hi_q, lo_q};

    // Output code is transparent to the staging word while transfer is on
    always_ff @(posedge clk) begin
        if (!rst_n)       code <= '0;
        else if (xfer_en) code <= stage_word;
    end
endmodule

// File: rtl/dual_dac_loader.sv
// Double-buffered, byte-fed loader for two 12-bit converter codes.
// Assumes cs_n, wr_n, ld_n, addr and data are asynchronous to clk; all of
// them pass through synchronizers of equal depth so that they stay aligned.
module dual_dac_loader #(
    parameter int BUS_W       = ddl_pkg::BUS_W,
    parameter int CODE_W      = ddl_pkg::CODE_W,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = ddl_pkg::SEL_W,
    localparam int NPART      = ddl_pkg::NUM_PARTS,
    localparam int NCH        = ddl_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [SEL_W-1:0]  addr,
    input  logic [BUS_W-1:0]  data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    logic [2:0]             strb_s;
    logic                   cs_s, wr_s, ld_s;
    logic [SEL_W+BUS_W-1:0] pay_s;
    logic [SEL_W-1:0]       addr_s;
    logic [BUS_W-1:0]       bus_s;
    logic                   wr_act;
    logic [NPART-1:0]       part_en;
    logic [CODE_W-1:0]      stage_w [NCH];
    logic [CODE_W-1:0]      code_w  [NCH];
    logic [CODE_W-1:0]      stage_a, stage_b;

    ddl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .d_in({cs_n, wr_n, ld_n}), .d_out(strb_s)
    );

    ddl_sync #(.W(SEL_W+BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pay_sync (
        .clk(clk), .rst_n(rst_n), .d_in({addr, data}), .d_out(pay_s)
    );

    assign {cs_s, wr_s, ld_s} = strb_s;
    assign {addr_s, bus_s}    = pay_s;

    // Write window: both bus strobes low in the synchronized domain
    assign wr_act = !cs_s && !wr_s;

    // Decode the address into one staging-part enable
    always_comb begin
        part_en = '0;
        if (wr_act) part_en[addr_s] = 1'b1;
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            ddl_channel #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_ch (
                .clk(clk), .rst_n(rst_n),
                .lo_en(part_en[ddl_pkg::part_idx(c, 1'b0)]),
                .hi_en(part_en[ddl_pkg::part_idx(c, 1'b1)]),
                .bus(bus_s),
                .xfer_en(!ld_s),
                .stage_word(stage_w[c]),
                .code(code_w[c])
            );
        end
    endgenerate

    assign stage_a = stage_w[0];
    assign stage_b = stage_w[1];
    assign code_a  = code_w[0];
    assign code_b  = code_w[1];
endmodule

// File: rtl/dual_dac_loader_chk.sv
// Checker for the loader: relates synchronized strobes, part enables,
// staging words and output codes over time. Attached by bind below.
module dual_dac_loader_chk #(
    parameter int BUS_W  = 8,
    parameter int CODE_W = 12,
    parameter int NPART  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_s,
    input logic              wr_act,
    input logic [NPART-1:0]  part_en,
    input logic [BUS_W-1:0]  bus_s,
    input logic [CODE_W-1:0] stage_a,
    input logic [CODE_W-1:0] stage_b,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b
);
    localparam int HI_W = CODE_W - BUS_W;

    // R2
    one_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(part_en));

    // R3
    stage_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_a != $past(stage_a) || stage_b != $past(stage_b)) |-> $past(wr_act));

    // R4
    hi_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(part_en[1]) |-> stage_a[CODE_W-1:BUS_W] == $past(bus_s[HI_W-1:0]));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a != $past(code_a) || code_b != $past(code_b)) |-> !$past(ld_s));

    // R6
    code_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_s) |-> (code_a == $past(stage_a) && code_b == $past(stage_b)));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(
    .BUS_W(BUS_W), .CODE_W(CODE_W), .NPART(NPART)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .wr_act(wr_act),
    .part_en(part_en), .bus_s(bus_s), .stage_a(stage_a), .stage_b(stage_b),
    .code_a(code_a), .code_b(code_b)
);

// File: tb/dual_dac_loader_bench.sv
`timescale 1ns/1ps
module dual_dac_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [11:0] code_a, code_b;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [11:0] m_stage [2];
    logic [11:0] m_code  [2];

    always #4 clk = ~clk;

    dual_dac_loader u_dual_dac_loader (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
        .addr(addr), .data(data), .code_a(code_a), .code_b(code_b)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %03h expected %03h", req, got, exp);
        end
    endtask

    task automatic check_both(input string req);
        check(req, code_a, m_code[0]);
        check(req, code_b, m_code[1]);
    endtask

    // Model of a write landing in the staging word: R2 map, R4 right-justified nibble
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        int ch = a[1];
        if (a[0]) m_stage[ch][11:8] = d[3:0];
        else      m_stage[ch][7:0]  = d;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; data = d; cs_n = 1'b0; wr_n = 1'b0;
        wait_cyc(3);
        cs_n = 1'b1; wr_n = 1'b1;
        wait_cyc(4);
        model_write(a, d);
    endtask

    task automatic ld_pulse();
        ld_n = 1'b0;
        wait_cyc(4);
        ld_n = 1'b1;
        wait_cyc(4);
        m_code[0] = m_stage[0];
        m_code[1] = m_stage[1];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        m_stage[0] = '0; m_stage[1] = '0; m_code[0] = '0; m_code[1] = '0;
        wait_cyc(3);
        // R1: reset state
        check_both("R1");
        rst_n = 1'b1;
        wait_cyc(2);
        ld_pulse();
        check_both("R1 staging zero");

        // R2 R4 R5: every byte to every address
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 256; d++) begin
                bus_write(a[1:0], d[7:0]);
                check_both("R5 no change while load high");
                ld_pulse();
                check_both("R2/R4 address map and nibble");
            end
        end

        // R3: chip select high blocks the write
        addr = 2'd0; data = 8'h5A; cs_n = 1'b1; wr_n = 1'b0;
        wait_cyc(3); wr_n = 1'b1; wait_cyc(4);
        // R3: write high blocks the write
        addr = 2'd2; data = 8'hA5; cs_n = 1'b0; wr_n = 1'b1;
        wait_cyc(3); cs_n = 1'b1; wait_cyc(4);
        // R8: load pulse with chip select high transfers unchanged words
        ld_pulse();
        check_both("R3/R8 blocked writes");

        // R8: load transfers both channels while no write happens
        bus_write(2'd0, 8'h3C); bus_write(2'd3, 8'hF9);
        ld_pulse();
        check("R8 channel A", code_a, 12'hF3C);
        check("R8 channel B", code_b, m_code[1]);

        // R6: transparent while load low
        ld_n = 1'b0;
        wait_cyc(4);
        addr = 2'd1; data = 8'h07; cs_n = 1'b0; wr_n = 1'b0;
        wait_cyc(3); cs_n = 1'b1; wr_n = 1'b1;
        wait_cyc(5);
        model_write(2'd1, 8'h07);
        check("R6 follow during load low", code_a, m_stage[0]);
        ld_n = 1'b1;
        wait_cyc(4);
        m_code[0] = m_stage[0]; m_code[1] = m_stage[1];

        // R7: hold after rising edge
        bus_write(2'd0, 8'h11); bus_write(2'd2, 8'h22);
        check_both("R7 hold after release");

        // R9: overlapped load held 3 cycles past write end
        ld_n = 1'b0;
        addr = 2'd2; data = 8'h99; cs_n = 1'b0; wr_n = 1'b0;
        wait_cyc(3); cs_n = 1'b1; wr_n = 1'b1;
        wait_cyc(3); ld_n = 1'b1;
        wait_cyc(4);
        model_write(2'd2, 8'h99);
        m_code[0] = m_stage[0]; m_code[1] = m_stage[1];
        check_both("R9 overlap capture");

        // R10: data changes mid-write; last value is kept
        addr = 2'd3; data = 8'h01; cs_n = 1'b0; wr_n = 1'b0;
        wait_cyc(3); data = 8'h0E; wait_cyc(3);
        cs_n = 1'b1; wr_n = 1'b1; wait_cyc(4);
        model_write(2'd3, 8'h0E);
        ld_pulse();
        check("R10 last value kept", code_b, m_code[1]);
        check("R10 expected word", code_b, {4'hE, 8'h99});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule